// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs once after reset and starts the processor. It picks a boot base address, reads two 32-bit words from it over a synchronous memory read port, and keeps them in a stack-pointer register and a program-counter register. It then opens instruction fetch at the loaded program counter.

The boot base is chosen by two boot-select pins.
- Two encodings map either the boot ROM or the internal flash onto address zero. In that case the fetch starts at zero.
- The remaining encoding takes the base from a 14-bit option value placed on a 64 KB boundary. This reaches any base from 0x00000000 to 0x3FFF0000.

The pins and the option value are captured once, in the first cycle after reset is released. The memory port has a valid/ready request and a response with any latency. An error response during either fetch parks the block in a lockup state until the next reset.

Top module: `vecfetch_seq`

## Requirements
- R1: In either alias mode the first read request after reset is at address 0x00000000.
- R2: Exactly two reads are made: the first at the boot base, the second at base+4. No other request follows.
- R3: The stack-pointer output holds the first word with bits [1:0] cleared.
- R4: The program-counter output holds the second word with bit 0 cleared.
- R5: `fetch_enable` stays low until both words are loaded.
  - It rises in the cycle after the second response.
  - `boot_done` is high for exactly that first cycle.
- R6: The boot-select pins map to the alias output as follows:
  - `boot_sel`=00 gives `alias_sel`=01 (boot ROM at zero).
  - `boot_sel`=01 gives `alias_sel`=10 (flash at zero).
  - `boot_sel`=1x gives `alias_sel`=00 (no alias, flexible base).
- R7: In flexible mode the base is {2'b00, `opt_base`[13:0], 16'h0000}.
- R8: `boot_sel` and `opt_base` are sampled only in the first clock after reset deasserts. Later changes have no effect on the addresses, the alias output or the loaded values.
- R9: Request handshake and response wait:
  - An unaccepted request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready`.
  - After acceptance the block drops the request and waits any number of cycles for `mem_rsp_valid`.
- R10: A response with `mem_rsp_err` high moves the block to lockup. In lockup:
  - `lockup` stays high until reset.
  - No further request is made.
  - `fetch_enable` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 2 | Boot-select pins |
| opt_base | input | 14 | Flexible boot base, address bits [29:16] |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 32 | Read request address |
| mem_req_ready | input | 1 | Request accepted this cycle |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Bus error with the response |
| alias_sel | output | 2 | Memory aliased at zero: 01 ROM, 10 flash, 00 none |
| sp_out | output | 32 | Loaded stack pointer |
| pc_out | output | 32 | Loaded program counter |
| fetch_enable | output | 1 | Instruction fetch may begin at pc_out |
| boot_done | output | 1 | One-cycle pulse on entry to run |
| lockup | output | 1 | Fetch failed with a bus error |

## Verification
Pin capture and the first request:
- The pins are captured on the first rising edge with reset high.
- The first request is visible in the cycle after that edge.

Handshake and response timing:
- A request accepted on an edge is withdrawn in the cycle after it.
- A response consumed on an edge shows its effect in the cycle after it. That effect is the next request, the run outputs with the `boot_done` pulse, or `lockup`.
- `boot_done` is low again one cycle later.

The bench drives the port on falling edges and checks on falling edges. Each check falls in the cycle after the edge that causes it. The latency and ready stalls are varied so that no check depends on a fixed count.

// File: rtl/vfseq_pkg.sv
package vfseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH_SP = 3'd1,
        ST_FETCH_PC = 3'd2,
        ST_RUN      = 3'd3,
        ST_LOCKUP   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        ALIAS_NONE  = 2'b00,
        ALIAS_ROM   = 2'b01,
        ALIAS_FLASH = 2'b10
    } alias_e;
endpackage

// File: rtl/vfseq_base_sel.sv
module vfseq_base_sel #(
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 2,
    parameter int OPT_W   = 14,
    parameter int OPT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [SEL_W-1:0]  boot_sel,
    input  logic [OPT_W-1:0]  opt_base,
    output logic [ADDR_W-1:0] base_addr,
    output logic [1:0]        alias_sel
);
    import vfseq_pkg::*;

    localparam int HI_PAD = ADDR_W - OPT_W - OPT_LSB;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [OPT_W-1:0] opt;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (capture) begin
            cap_d.sel = boot_sel;
            cap_d.opt = opt_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    logic flex_mode;
    assign flex_mode = cap_q.sel[SEL_W-1];

    generate
        if (HI_PAD > 0) begin : g_pad
            assign base_addr = flex_mode ? {{HI_PAD{1'b0}}, cap_q.opt, {OPT_LSB{1'b0}}}
                                         : '0;
        end else begin : g_nopad
            assign base_addr = flex_mode ? {cap_q.opt, {OPT_LSB{1'b0}}} : '0;
        end
    endgenerate

    always_comb begin
        if (flex_mode)        alias_sel = ALIAS_NONE;
        else if (cap_q.sel[0]) alias_sel = ALIAS_FLASH;
        else                   alias_sel = ALIAS_ROM;
    end
endmodule

// File: rtl/vfseq_fsm.sv
module vfseq_fsm #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic              capture,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              load_sp,
    output logic              load_pc,
    output logic              fetch_enable,
    output logic              boot_done,
    output logic              lockup
);
    import vfseq_pkg::*;

    localparam logic [ADDR_W-1:0] PC_OFS = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        seq_state_e st;
        logic       sent;
        logic       done_pls;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d          = fsm_q;
        fsm_d.done_pls = 1'b0;
        capture        = 1'b0;
        mem_req_valid  = 1'b0;
        mem_req_addr   = base_addr;
        load_sp        = 1'b0;
        load_pc        = 1'b0;
        case (fsm_q.st)
            ST_IDLE: begin
                capture    = 1'b1;
                fsm_d.st   = ST_FETCH_SP;
                fsm_d.sent = 1'b0;
            end
            ST_FETCH_SP, ST_FETCH_PC: begin
                if (fsm_q.st == ST_FETCH_PC) mem_req_addr = base_addr + PC_OFS;
                if (!fsm_q.sent) begin
                    mem_req_valid = 1'b1;
                    if (mem_req_ready) fsm_d.sent = 1'b1;
                end else if (mem_rsp_valid) begin
                    fsm_d.sent = 1'b0;
                    if (mem_rsp_err) begin
                        fsm_d.st = ST_LOCKUP;
                    end else if (fsm_q.st == ST_FETCH_SP) begin
                        load_sp  = 1'b1;
                        fsm_d.st = ST_FETCH_PC;
                    end else begin
                        load_pc        = 1'b1;
                        fsm_d.st       = ST_RUN;
                        fsm_d.done_pls = 1'b1;
                    end
                end
            end
            ST_RUN:    fsm_d.st = ST_RUN;
            ST_LOCKUP: fsm_d.st = ST_LOCKUP;
            default:   fsm_d.st = ST_LOCKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, sent: 1'b0, done_pls: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign fetch_enable = (fsm_q.st == ST_RUN);
    assign lockup       = (fsm_q.st == ST_LOCKUP);
    assign boot_done    = fsm_q.done_pls;
endmodule

// File: rtl/vfseq_vec_regs.sv
module vfseq_vec_regs #(
    parameter int DATA_W     = 32,
    parameter int SP_CLR_LSB = 2,
    parameter int PC_CLR_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_sp,
    input  logic              load_pc,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] pc_out
);
    localparam logic [DATA_W-1:0] SP_MASK = {DATA_W{1'b1}} << SP_CLR_LSB;
    localparam logic [DATA_W-1:0] PC_MASK = {DATA_W{1'b1}} << PC_CLR_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] pc;
    } vec_t;

    vec_t vec_d, vec_q;

    always_comb begin
        vec_d = vec_q;
        if (load_sp) vec_d.sp = rd_data & SP_MASK;
        if (load_pc) vec_d.pc = rd_data & PC_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    assign sp_out = vec_q.sp;
    assign pc_out = vec_q.pc;
endmodule

// File: rtl/vecfetch_seq.sv
module vecfetch_seq #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int OPT_W   = 14,
    parameter int OPT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_sel,
    input  logic [OPT_W-1:0]  opt_base,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic [1:0]        alias_sel,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              fetch_enable,
    output logic              boot_done,
    output logic              lockup
);
    localparam int WORD_BYTES = DATA_W / 8;

    logic              capture;
    logic              load_sp;
    logic              load_pc;
    logic [ADDR_W-1:0] base_addr;

    vfseq_base_sel #(
        .ADDR_W (ADDR_W),
        .SEL_W  (2),
        .OPT_W  (OPT_W),
        .OPT_LSB(OPT_LSB)
    ) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .boot_sel (boot_sel),
        .opt_base (opt_base),
        .base_addr(base_addr),
        .alias_sel(alias_sel)
    );

    vfseq_fsm #(
        .ADDR_W    (ADDR_W),
        .WORD_BYTES(WORD_BYTES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_addr    (base_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err  (mem_rsp_err),
        .capture      (capture),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .load_sp      (load_sp),
        .load_pc      (load_pc),
        .fetch_enable (fetch_enable),
        .boot_done    (boot_done),
        .lockup       (lockup)
    );

    vfseq_vec_regs #(
        .DATA_W    (DATA_W),
        .SP_CLR_LSB(2),
        .PC_CLR_LSB(1)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_sp(load_sp),
        .load_pc(load_pc),
        .rd_data(mem_rsp_data),
        .sp_out (sp_out),
        .pc_out (pc_out)
    );
endmodule

// File: rtl/vfseq_checker.sv
module vfseq_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic [1:0]        alias_sel,
    input logic [DATA_W-1:0] sp_out,
    input logic [DATA_W-1:0] pc_out,
    input logic              fetch_enable,
    input logic              boot_done,
    input logic              lockup
);
    a_r1_alias_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && alias_sel != 2'b00) |-> mem_req_addr[ADDR_W-1:3] == '0);

    a_r2_no_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_enable |-> !mem_req_valid);

    a_r3_sp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_enable |-> sp_out[1:0] == 2'b00);

    a_r4_pc_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_enable |-> pc_out[0] == 1'b0);

    a_r5_enable_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_enable) |-> boot_done);

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> !boot_done && fetch_enable);

    a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[15:0] == 16'h0000 || mem_req_addr[15:0] == 16'h0004));

    a_r8_alias_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || fetch_enable || lockup) |=> $stable(alias_sel));

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

    a_r10_lockup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |=> lockup);

    a_r10_lockup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |-> !mem_req_valid && !fetch_enable);
endmodule

bind vecfetch_seq vfseq_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_vfseq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .alias_sel    (alias_sel),
    .sp_out       (sp_out),
    .pc_out       (pc_out),
    .fetch_enable (fetch_enable),
    .boot_done    (boot_done),
    .lockup       (lockup)
);

// File: tb/vecfetch_seq_bench.sv
module vecfetch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_sel = 2'b00;
    logic [13:0] opt_base = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic [1:0]  alias_sel;
    logic [31:0] sp_out;
    logic [31:0] pc_out;
    logic        fetch_enable;
    logic        boot_done;
    logic        lockup;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    vecfetch_seq u_vecfetch_seq (
        .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .opt_base(opt_base),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .alias_sel(alias_sel), .sp_out(sp_out), .pc_out(pc_out),
        .fetch_enable(fetch_enable), .boot_done(boot_done), .lockup(lockup)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor side of the scoreboard: pops the expected address of an accepted request
    task automatic sb_pop_check(input logic [31:0] addr);
        if (exp_q.size() == 0) chk("R2 unexpected request", addr, 32'hxxxxxxxx);
        else chk("R1/R2/R7 request address", addr, exp_q.pop_front());
    endtask

    task automatic serve(input logic [31:0] data, input logic err, input int rw, input int lat);
        logic [31:0] a0;
        int n = 0;
        while (!mem_req_valid && n < 20) begin @(negedge clk); n++; end
        chk("R9 request seen", 32'(mem_req_valid), 32'd1);
        a0 = mem_req_addr;
        sb_pop_check(a0);
        repeat (rw) begin
            @(negedge clk);
            chk("R9 valid held", 32'(mem_req_valid), 32'd1);
            chk("R9 addr stable", mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R9 request withdrawn", 32'(mem_req_valid), 32'd0);
        repeat (lat) begin
            @(negedge clk);
            chk("R9 waits for response", 32'(mem_req_valid), 32'd0);
        end
        chk("R5 no enable before load", 32'(fetch_enable), 32'd0);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        mem_rsp_err   = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        mem_rsp_data  = 32'hDEAD_BEEF;
    endtask

    task automatic boot_run(input logic [1:0] sel, input logic [13:0] opt,
                            input logic [31:0] w0, input logic [31:0] w1,
                            input int rw, input int lat, input int err_at);
        logic [31:0] base;
        logic [1:0]  exp_alias;
        rst_n = 1'b0;
        boot_sel = sel;
        opt_base = opt;
        exp_q.delete();
        repeat (3) @(negedge clk);
        chk("reset fetch_enable", 32'(fetch_enable), 32'd0);
        chk("reset boot_done", 32'(boot_done), 32'd0);
        chk("reset req", 32'(mem_req_valid), 32'd0);
        chk("reset lockup", 32'(lockup), 32'd0);
        base      = sel[1] ? {2'b00, opt, 16'h0000} : 32'h0;
        exp_alias = sel[1] ? 2'b00 : (sel[0] ? 2'b10 : 2'b01);
        exp_q.push_back(base);
        if (err_at != 1) exp_q.push_back(base + 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: change pins after the capture edge
        boot_sel = ~sel;
        opt_base = ~opt;
        chk("R6 alias mapping", 32'(alias_sel), 32'(exp_alias));
        serve(w0, err_at == 1, rw, lat);
        if (err_at == 1) begin
            repeat (4) begin
                chk("R10 lockup held", 32'(lockup), 32'd1);
                chk("R10 no request", 32'(mem_req_valid), 32'd0);
                chk("R10 no enable", 32'(fetch_enable), 32'd0);
                @(negedge clk);
            end
            return;
        end
        chk("R5 still off after first word", 32'(fetch_enable), 32'd0);
        serve(w1, err_at == 2, rw, lat);
        if (err_at == 2) begin
            repeat (4) begin
                chk("R10 lockup held", 32'(lockup), 32'd1);
                chk("R10 no request", 32'(mem_req_valid), 32'd0);
                chk("R10 no enable", 32'(fetch_enable), 32'd0);
                chk("R10 no done pulse", 32'(boot_done), 32'd0);
                @(negedge clk);
            end
            return;
        end
        chk("R5 enable", 32'(fetch_enable), 32'd1);
        chk("R5 done pulse", 32'(boot_done), 32'd1);
        chk("R3 stack pointer", sp_out, w0 & 32'hFFFF_FFFC);
        chk("R4 program counter", pc_out, w1 & 32'hFFFF_FFFE);
        chk("R8 alias unchanged", 32'(alias_sel), 32'(exp_alias));
        chk("R2 all reads done", 32'(exp_q.size()), 32'd0);
        @(negedge clk);
        chk("R5 pulse ends", 32'(boot_done), 32'd0);
        chk("R5 enable held", 32'(fetch_enable), 32'd1);
        repeat (3) begin
            @(negedge clk);
            chk("R2 no third request", 32'(mem_req_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        boot_run(2'b00, 14'h1234, 32'h2000_1003, 32'h0800_0101, 0, 0, 0); // R1 R6 ROM
        boot_run(2'b01, 14'h0ABC, 32'h2002_0006, 32'h0800_4323, 2, 3, 0); // R1 R6 flash, R9 stalls
        boot_run(2'b10, 14'h3FFF, 32'h3000_FFFF, 32'hFFFF_FFFF, 1, 1, 0); // R7 top base
        boot_run(2'b11, 14'h0001, 32'h0000_0001, 32'h0001_0000, 0, 5, 0); // R7 64 KB base
        boot_run(2'b00, 14'h0000, 32'h1111_1111, 32'h2222_2222, 1, 2, 1); // R10 first fetch
        boot_run(2'b10, 14'h0123, 32'h2000_0000, 32'h0123_0041, 0, 1, 2); // R10 second fetch
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule